// File: doc/BRIEF.md
# Ring Node Link and Enumeration Controller

This block sits in every node of a one-way ring of processing nodes. Each node has a single inbound link from its upstream neighbour and a single outbound link to its downstream neighbour. Both links use a valid/ready handshake and carry a data word plus one flag bit. The node relays traffic it does not own. It learns its ring position during start-up. It then takes in one tile of pixels addressed to it, holds the tile for a local processing engine, and sends the result back around the ring when the engine signals completion.

Start-up works like this. The ring master sends a flagged word holding the node count. Each node subtracts one, stores the result as its own position, and passes the decremented word on. Later traffic is framed as packets. A packet is an unflagged header word holding a destination position, followed by exactly `TILE_DIM*TILE_DIM` pixel words. A node stores a packet addressed to itself into a local buffer. Any other packet passes through unchanged. The processing engine reads and rewrites the buffer through a side port. It then pulses `done`. The node answers by emitting a return packet whose header is all ones, a value no node position can take, so every other node forwards it toward the master.

Top module: `ring_node_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `out_vld` and `tile_held` are 0. Once reset is released with an empty ring, `in_rdy` is 1.
- R2: At a packet boundary, an accepted word with `in_ctl`=1 and value N is re-emitted with `out_ctl`=1 and value N-1, and `node_pos` becomes N-1.
- R3: No word is ever lost. When the output buffer (depth `OUT_DEPTH`) is full, `in_rdy` drops for any word that would need it. A word on the output stays unchanged while `out_rdy` is low, and words leave in the order they were accepted.
- R4: A forwarded word accepted at clock edge k, with the output buffer empty, is on `out_data` with `out_vld` high right after edge k.
- R5: A header with `in_ctl`=0 whose value differs from `node_pos` is forwarded unchanged, together with the following `TILE_DIM*TILE_DIM` words. Before the first enumeration, every unflagged word is forwarded unchanged.
- R6: A header with `in_ctl`=0 equal to `node_pos` starts a receive. The header and the next `TILE_DIM*TILE_DIM` words are not emitted. Word i's low `PIX_W` bits are stored at buffer index i. `tile_held` rises right after the last word is accepted.
- R7: While `tile_held` is high, a header equal to `node_pos` is stalled (`in_rdy`=0), while packets for other positions still pass through.
- R8: A `done` pulse while a tile is held starts a return at the next packet boundary. The node emits header 0xFFFF (all ones) with flag 0, then each buffered pixel, zero-extended, in index order 0 upward. `in_rdy` stays low for the whole return. `tile_held` falls after the last word, and a new tile can then be received.
- R9: A `done` pulse while no tile is held has no effect: nothing is emitted and `tile_held` stays 0.
- R10: While a tile is held, `proc_we` writes `proc_wdata` at `proc_addr`. `proc_rdata` shows the word at `proc_addr` without a clock. The returned tile carries the written values.
- R11: A flagged word arriving at a packet boundary after enumeration re-enumerates the node as in R2. `node_pos` changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Upstream word valid |
| in_ctl | input | 1 | Upstream flag bit (1 = enumeration word) |
| in_data | input | DW | Upstream data word |
| in_rdy | output | 1 | Node accepts the upstream word |
| out_vld | output | 1 | Downstream word valid |
| out_ctl | output | 1 | Downstream flag bit |
| out_data | output | DW | Downstream data word |
| out_rdy | input | 1 | Downstream neighbour accepts the word |
| done | input | 1 | Processing finished strobe |
| proc_we | input | 1 | Engine write enable into the tile buffer |
| proc_addr | input | AW | Engine buffer index |
| proc_wdata | input | PIX_W | Engine write pixel |
| proc_rdata | output | PIX_W | Pixel at proc_addr |
| tile_held | output | 1 | A received tile is buffered or being returned |
| node_pos | output | DW | Position learned at enumeration |

## Verification
A wrong receive counter or a missed packet boundary shows up at the ports within one packet. The following header is then forwarded, swallowed or misparsed, so the words leaving the node drift away from the expected stream on the very next packet. A stuck tile state shows up differently. Either `tile_held` never falls after `done`, or a header for the node's own position is stalled forever. A wrong position register changes the decision between forwarding and receiving on the next header. Back-pressure faults appear as a changed or missing word as soon as `out_rdy` is held low for more cycles than the output buffer is deep.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;

   // inbound parser position within the word stream
   typedef enum logic [1:0] {
      RX_ENUM = 2'd0,   // waiting for the first enumeration word
      RX_HDR  = 2'd1,   // packet boundary: next word is a header
      RX_PASS = 2'd2,   // relaying a packet for another node
      RX_RECV = 2'd3    // storing a packet for this node
   } rx_st_e;

   // ownership of the local tile buffer
   typedef enum logic [1:0] {
      TL_EMPTY = 2'd0,
      TL_HELD  = 2'd1,
      TL_SEND  = 2'd2
   } tl_st_e;

endpackage

// File: rtl/ring_link_fifo.sv
module ring_link_fifo #(
   parameter int unsigned W     = 17,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] wdata,
   output logic         full,
   output logic         vld,
   input  logic         pop_rdy,
   output logic [W-1:0] rdata
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("ring_link_fifo: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic         v_q;
         logic [W-1:0] d_q;

         always_ff @(posedge clk) begin
            if (rst)                v_q <= 1'b0;
            else if (push)          v_q <= 1'b1;
            else if (v_q && pop_rdy) v_q <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (push) d_q <= wdata;
         end

         assign full  = v_q;
         assign vld   = v_q;
         assign rdata = d_q;
      end else begin : g_ring
         localparam int unsigned PW = $clog2(DEPTH);
         localparam int unsigned NW = $clog2(DEPTH + 1);

         logic [W-1:0]  mem [DEPTH];
         logic [PW-1:0] wp_q, rp_q;
         logic [NW-1:0] cnt_q;
         logic          do_wr, do_rd;

         function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
         endfunction

         assign full  = (cnt_q == NW'(DEPTH));
         assign vld   = (cnt_q != '0);
         assign rdata = mem[rp_q];
         assign do_wr = push && !full;
         assign do_rd = vld && pop_rdy;

         always_ff @(posedge clk) begin
            if (rst) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_wr) wp_q <= step(wp_q);
               if (do_rd) rp_q <= step(rp_q);
               if (do_wr && !do_rd)      cnt_q <= cnt_q + NW'(1);
               else if (do_rd && !do_wr) cnt_q <= cnt_q - NW'(1);
            end
         end

         always_ff @(posedge clk) begin
            if (do_wr) mem[wp_q] <= wdata;
         end
      end
   endgenerate

endmodule

// File: rtl/ring_tile_buf.sv
module ring_tile_buf #(
   parameter int unsigned W  = 8,
   parameter int unsigned N  = 64,
   parameter int unsigned AW = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [W-1:0]  rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_b
);

   generate
      if ((1 << AW) < N) begin : g_bad_aw
         $error("ring_tile_buf: AW too narrow for N");
      end
   endgenerate

   logic [W-1:0] mem [N];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/ring_node_ctrl.sv
module ring_node_ctrl
   import ring_node_pkg::*;
#(
   parameter int unsigned DW        = 16,
   parameter int unsigned PIX_W     = 8,
   parameter int unsigned TILE_DIM  = 8,
   parameter int unsigned OUT_DEPTH = 2,
   localparam int unsigned TILE_WORDS = TILE_DIM * TILE_DIM,
   localparam int unsigned AW = (TILE_WORDS > 1) ? $clog2(TILE_WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   input  logic             in_ctl,
   input  logic [DW-1:0]    in_data,
   output logic             in_rdy,
   output logic             out_vld,
   output logic             out_ctl,
   output logic [DW-1:0]    out_data,
   input  logic             out_rdy,
   input  logic             done,
   input  logic             proc_we,
   input  logic [AW-1:0]    proc_addr,
   input  logic [PIX_W-1:0] proc_wdata,
   output logic [PIX_W-1:0] proc_rdata,
   output logic             tile_held,
   output logic [DW-1:0]    node_pos
);

   localparam int unsigned CW       = $clog2(TILE_WORDS + 1);
   localparam logic [DW-1:0] RET_ID = '1;
   localparam logic [CW-1:0] LAST_IX = CW'(TILE_WORDS - 1);
   localparam logic [CW-1:0] N_WORDS = CW'(TILE_WORDS);

   generate
      if (PIX_W == 0 || PIX_W > DW) begin : g_bad_pix
         $error("ring_node_ctrl: PIX_W must be 1..DW");
      end
      if (TILE_DIM == 0) begin : g_bad_dim
         $error("ring_node_ctrl: TILE_DIM must be nonzero");
      end
      if (DW < 2) begin : g_bad_dw
         $error("ring_node_ctrl: DW must be at least 2");
      end
   endgenerate

   rx_st_e        rx_q;
   tl_st_e        tl_q;
   logic [DW-1:0] pos_q;
   logic [CW-1:0] rcnt_q;
   logic [CW-1:0] scnt_q;
   logic          done_pend_q;

   logic          fifo_full;
   logic          push;
   logic [DW:0]   push_word;
   logic          acc;
   logic          boundary;
   logic          self_hdr;
   logic          start_ret;
   logic          sending;
   logic          buf_we;
   logic [AW-1:0] buf_waddr;
   logic [PIX_W-1:0] buf_wdata;
   logic [AW-1:0] send_addr;
   logic [PIX_W-1:0] send_pix;
   logic [DW:0]   fifo_rdata;

   assign boundary  = (rx_q == RX_ENUM) || (rx_q == RX_HDR);
   assign self_hdr  = (rx_q == RX_HDR) && !in_ctl && (in_data == pos_q);
   assign start_ret = done_pend_q && (tl_q == TL_HELD) && (rx_q == RX_HDR);
   assign sending   = (tl_q == TL_SEND);

   // inbound acceptance: a return in flight owns the outbound link
   always_comb begin
      if (sending || start_ret)  in_rdy = 1'b0;
      else if (rx_q == RX_RECV)  in_rdy = 1'b1;
      else if (self_hdr)         in_rdy = (tl_q == TL_EMPTY);
      else                       in_rdy = !fifo_full;
   end

   assign acc = in_vld && in_rdy;

   assign send_addr = AW'(scnt_q - CW'(1));

   // outbound word selection
   always_comb begin
      push      = 1'b0;
      push_word = {1'b0, in_data};
      if (sending) begin
         push      = !fifo_full;
         push_word = (scnt_q == '0) ? {1'b0, RET_ID} : {1'b0, DW'(send_pix)};
      end else if (acc && (rx_q != RX_RECV) && !self_hdr) begin
         push = 1'b1;
         if (boundary && in_ctl) push_word = {1'b1, in_data - DW'(1)};
         else                    push_word = {in_ctl, in_data};
      end
   end

   // buffer write: inbound tile words first, engine writes while held
   always_comb begin
      buf_we    = 1'b0;
      buf_waddr = proc_addr;
      buf_wdata = proc_wdata;
      if (acc && (rx_q == RX_RECV)) begin
         buf_we    = 1'b1;
         buf_waddr = AW'(rcnt_q);
         buf_wdata = in_data[PIX_W-1:0];
      end else if (proc_we && (tl_q == TL_HELD)) begin
         buf_we = 1'b1;
      end
   end

   // inbound parser
   always_ff @(posedge clk) begin
      if (rst) begin
         rx_q   <= RX_ENUM;
         pos_q  <= '0;
         rcnt_q <= '0;
      end else if (acc) begin
         unique case (rx_q)
            RX_ENUM: begin
               if (in_ctl) begin
                  pos_q <= in_data - DW'(1);
                  rx_q  <= RX_HDR;
               end
            end
            RX_HDR: begin
               rcnt_q <= '0;
               if (in_ctl)        pos_q <= in_data - DW'(1);
               else if (self_hdr) rx_q  <= RX_RECV;
               else               rx_q  <= RX_PASS;
            end
            RX_PASS, RX_RECV: begin
               rcnt_q <= rcnt_q + CW'(1);
               if (rcnt_q == LAST_IX) rx_q <= RX_HDR;
            end
            default: rx_q <= RX_ENUM;
         endcase
      end
   end

   // tile ownership and return sequencing
   always_ff @(posedge clk) begin
      if (rst) begin
         tl_q        <= TL_EMPTY;
         scnt_q      <= '0;
         done_pend_q <= 1'b0;
      end else begin
         unique case (tl_q)
            TL_EMPTY: begin
               if (acc && (rx_q == RX_RECV) && (rcnt_q == LAST_IX)) tl_q <= TL_HELD;
            end
            TL_HELD: begin
               if (start_ret) begin
                  tl_q        <= TL_SEND;
                  scnt_q      <= '0;
                  done_pend_q <= 1'b0;
               end else if (done) begin
                  done_pend_q <= 1'b1;
               end
            end
            TL_SEND: begin
               if (push) begin
                  scnt_q <= scnt_q + CW'(1);
                  if (scnt_q == N_WORDS) tl_q <= TL_EMPTY;
               end
            end
            default: tl_q <= TL_EMPTY;
         endcase
      end
   end

   ring_link_fifo #(
      .W     (DW + 1),
      .DEPTH (OUT_DEPTH)
   ) i_out_fifo (
      .clk     (clk),
      .rst     (rst),
      .push    (push),
      .wdata   (push_word),
      .full    (fifo_full),
      .vld     (out_vld),
      .pop_rdy (out_rdy),
      .rdata   (fifo_rdata)
   );

   ring_tile_buf #(
      .W  (PIX_W),
      .N  (TILE_WORDS),
      .AW (AW)
   ) i_tile_buf (
      .clk     (clk),
      .we      (buf_we),
      .waddr   (buf_waddr),
      .wdata   (buf_wdata),
      .raddr_a (send_addr),
      .rdata_a (send_pix),
      .raddr_b (proc_addr),
      .rdata_b (proc_rdata)
   );

   assign out_ctl   = fifo_rdata[DW];
   assign out_data  = fifo_rdata[DW-1:0];
   assign tile_held = (tl_q != TL_EMPTY);
   assign node_pos  = pos_q;

endmodule

// File: rtl/ring_node_chk.sv
module ring_node_chk #(
   parameter int unsigned DW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          in_vld,
   input logic          in_ctl,
   input logic [DW-1:0] in_data,
   input logic          in_rdy,
   input logic          out_vld,
   input logic          out_ctl,
   input logic [DW-1:0] out_data,
   input logic          out_rdy,
   input logic          done,
   input logic          tile_held,
   input logic [DW-1:0] node_pos,
   input logic          fifo_full,
   input logic          sending,
   input logic          rx_boundary,
   input logic          rx_pass
);

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (!out_vld && !tile_held));

   p_enum_r2: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_rdy && in_ctl && rx_boundary) |=> (node_pos == $past(in_data) - DW'(1)));

   p_hold_out_r3: assert property (@(posedge clk) disable iff (rst)
      (out_vld && !out_rdy) |=> (out_vld && $stable(out_data) && $stable(out_ctl)));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      (fifo_full && rx_pass) |-> !in_rdy);

   p_self_stall_r7: assert property (@(posedge clk) disable iff (rst)
      (tile_held && rx_boundary && in_vld && !in_ctl && (in_data == node_pos)) |-> !in_rdy);

   p_ret_stall_r8: assert property (@(posedge clk) disable iff (rst)
      sending |-> !in_rdy);

   p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
      (done && !tile_held) |=> !sending);

   p_pos_stable_r11: assert property (@(posedge clk) disable iff (rst)
      !(in_vld && in_rdy && in_ctl && rx_boundary) |=> $stable(node_pos));

endmodule

bind ring_node_ctrl ring_node_chk #(.DW(DW)) i_chk (
   .clk         (clk),
   .rst         (rst),
   .in_vld      (in_vld),
   .in_ctl      (in_ctl),
   .in_data     (in_data),
   .in_rdy      (in_rdy),
   .out_vld     (out_vld),
   .out_ctl     (out_ctl),
   .out_data    (out_data),
   .out_rdy     (out_rdy),
   .done        (done),
   .tile_held   (tile_held),
   .node_pos    (node_pos),
   .fifo_full   (fifo_full),
   .sending     (sending),
   .rx_boundary (boundary),
   .rx_pass     (rx_q == ring_node_pkg::RX_PASS)
);

// File: tb/test_ring_node_ctrl.sv
`timescale 1ns/1ps
module test_ring_node_ctrl;

   localparam int unsigned DW = 16;
   localparam int unsigned PIX_W = 8;
   localparam int unsigned TILE_DIM = 8;
   localparam int unsigned TW = TILE_DIM * TILE_DIM;
   localparam int unsigned AW = $clog2(TW);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_vld = 1'b0, in_ctl = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic in_rdy;
   logic out_vld, out_ctl;
   logic [DW-1:0] out_data;
   logic out_rdy = 1'b1;
   logic done = 1'b0;
   logic proc_we = 1'b0;
   logic [AW-1:0] proc_addr = '0;
   logic [PIX_W-1:0] proc_wdata = '0;
   logic [PIX_W-1:0] proc_rdata;
   logic tile_held;
   logic [DW-1:0] node_pos;

   int n_cmp = 0;
   int n_bad = 0;
   int rdy_mode = 0;          // 0 always ready, 1 never, 2 random
   bit finished = 0;

   logic [DW:0] exp_q[$];
   string       tag_q[$];
   logic [DW-1:0] pos_m;
   logic [PIX_W-1:0] tile_m [TW];

   always #2 clk = ~clk;

   ring_node_ctrl #(.DW(DW), .PIX_W(PIX_W), .TILE_DIM(TILE_DIM), .OUT_DEPTH(2)) i_ring_node_ctrl (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_ctl(in_ctl), .in_data(in_data), .in_rdy(in_rdy),
      .out_vld(out_vld), .out_ctl(out_ctl), .out_data(out_data), .out_rdy(out_rdy), .done(done),
      .proc_we(proc_we), .proc_addr(proc_addr), .proc_wdata(proc_wdata), .proc_rdata(proc_rdata),
      .tile_held(tile_held), .node_pos(node_pos)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp_v, $time);
      end
   endtask

   task automatic exp_add(input logic c, input logic [DW-1:0] d, input string tag);
      exp_q.push_back({c, d});
      tag_q.push_back(tag);
   endtask

   // downstream side
   always @(negedge clk) begin
      case (rdy_mode)
         0: out_rdy = 1'b1;
         1: out_rdy = 1'b0;
         default: out_rdy = ($urandom % 4) != 0;
      endcase
   end

   always @(negedge clk) begin
      #1;
      if (!rst && out_vld && out_rdy) begin
         if (exp_q.size() == 0) begin
            chk(0, "R3 extra word", {15'd0, out_ctl, out_data}, 32'hDEAD);
         end else begin
            logic [DW:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({out_ctl, out_data} == e, t, {15'd0, out_ctl, out_data}, {15'd0, e});
         end
      end
   end

   function automatic logic [DW-1:0] other_dest(input logic [DW-1:0] p);
      return p + DW'(1 + ($urandom % 6));
   endfunction

   task automatic push(input logic c, input logic [DW-1:0] d);
      in_vld = 1'b1; in_ctl = c; in_data = d;
      #1;
      while (!in_rdy) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      in_vld = 1'b0;
   endtask

   task automatic drain();
      for (int t = 0; t < 5000 && exp_q.size() != 0; t++) @(negedge clk);
   endtask

   task automatic enumerate(input logic [DW-1:0] n, input string tag);
      exp_add(1'b1, n - DW'(1), tag);
      push(1'b1, n);
      pos_m = n - DW'(1);
      #1;
      chk(node_pos == pos_m, tag, {16'd0, node_pos}, {16'd0, pos_m});
      @(negedge clk);
   endtask

   task automatic send_tile(input logic [DW-1:0] dest, input string tag);
      bit own;
      own = (dest == pos_m);
      if (!own) exp_add(1'b0, dest, tag);
      push(1'b0, dest);
      for (int i = 0; i < TW; i++) begin
         logic [DW-1:0] w;
         w = DW'($urandom);
         if (own) tile_m[i] = w[PIX_W-1:0];
         else exp_add(1'b0, w, tag);
         push(1'b0, w);
      end
   endtask

   task automatic proc_write(input int a, input logic [PIX_W-1:0] v);
      proc_we = 1'b1; proc_addr = AW'(a); proc_wdata = v;
      @(negedge clk);
      proc_we = 1'b0;
      #1;
      chk(proc_rdata == v, "R10 readback", {24'd0, proc_rdata}, {24'd0, v});
      tile_m[a] = v;
      @(negedge clk);
   endtask

   task automatic return_tile();
      exp_add(1'b0, '1, "R8 header");
      for (int i = 0; i < TW; i++) exp_add(1'b0, DW'(tile_m[i]), "R8 pixel");
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      #1;
      chk(in_rdy == 1'b0, "R8 upstream stalled", {31'd0, in_rdy}, 32'd0);
      @(negedge clk);
      for (int t = 0; t < 3000 && tile_held; t++) @(negedge clk);
      chk(tile_held == 1'b0, "R8 tile released", {31'd0, tile_held}, 32'd0);
      drain();
   endtask

   initial begin
      int seed_sink;
      seed_sink = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R1
      chk(out_vld == 1'b0, "R1 out_vld", {31'd0, out_vld}, 32'd0);
      chk(in_rdy == 1'b1, "R1 in_rdy", {31'd0, in_rdy}, 32'd1);
      chk(tile_held == 1'b0, "R1 tile_held", {31'd0, tile_held}, 32'd0);
      @(negedge clk);

      // R4: one-register pass-through before enumeration (also R5)
      exp_add(1'b0, 16'h1234, "R5 pre-enum word");
      push(1'b0, 16'h1234);
      #1;
      chk(out_vld == 1'b1 && out_data == 16'h1234, "R4 latency", {15'd0, out_vld, out_data}, {15'd0, 1'b1, 16'h1234});
      @(negedge clk);
      drain();

      // R3: back-pressure with the output held
      rdy_mode = 1;
      @(negedge clk);
      exp_add(1'b0, 16'h00A1, "R3 order");
      push(1'b0, 16'h00A1);
      exp_add(1'b0, 16'h00A2, "R3 order");
      push(1'b0, 16'h00A2);
      in_vld = 1'b1; in_ctl = 1'b0; in_data = 16'h00A3;
      #1;
      chk(in_rdy == 1'b0, "R3 stall when full", {31'd0, in_rdy}, 32'd0);
      repeat (3) @(negedge clk);
      #1;
      chk(in_rdy == 1'b0, "R3 stall persists", {31'd0, in_rdy}, 32'd0);
      @(negedge clk);
      rdy_mode = 0;
      exp_add(1'b0, 16'h00A3, "R3 order");
      push(1'b0, 16'h00A3);
      drain();
      chk(exp_q.size() == 0, "R3 drained", exp_q.size(), 0);

      // R2: enumeration
      enumerate(16'd5, "R2 enumerate");
      drain();

      // R5: packet for another node
      send_tile(pos_m + DW'(2), "R5 pass");
      drain();

      // R9: done without a tile
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      chk(out_vld == 1'b0, "R9 nothing emitted", {31'd0, out_vld}, 32'd0);
      chk(tile_held == 1'b0, "R9 no tile", {31'd0, tile_held}, 32'd0);
      @(negedge clk);

      // R6: own tile
      send_tile(pos_m, "R6 receive");
      #1;
      chk(tile_held == 1'b1, "R6 tile_held", {31'd0, tile_held}, 32'd1);
      chk(out_vld == 1'b0 && exp_q.size() == 0, "R6 nothing emitted", {31'd0, out_vld}, 32'd0);
      @(negedge clk);

      // R7: own header stalled, others pass
      in_vld = 1'b1; in_ctl = 1'b0; in_data = pos_m;
      #1;
      chk(in_rdy == 1'b0, "R7 own header stalled", {31'd0, in_rdy}, 32'd0);
      repeat (4) @(negedge clk);
      #1;
      chk(in_rdy == 1'b0, "R7 still stalled", {31'd0, in_rdy}, 32'd0);
      @(negedge clk);
      in_vld = 1'b0;
      send_tile(other_dest(pos_m), "R7 pass while held");
      drain();

      // R10 then R8
      proc_write(0, 8'h5A);
      proc_write(TW - 1, 8'hC3);
      proc_write(17, 8'h00);
      return_tile();

      // R11: re-enumeration
      enumerate(16'd9, "R11 re-enumerate");
      drain();

      // random mix
      for (int it = 0; it < 14; it++) begin
         int kind;
         rdy_mode = 2;
         kind = $urandom % 4;
         if (kind == 0) begin
            send_tile(other_dest(pos_m), "R5 random pass");
         end else if (kind == 1) begin
            enumerate(DW'(2 + ($urandom % 30)), "R11 random");
         end else begin
            send_tile(pos_m, "R6 random receive");
            if (kind == 3) proc_write($urandom % TW, PIX_W'($urandom));
            return_tile();
         end
         drain();
      end
      rdy_mode = 0;
      drain();
      chk(exp_q.size() == 0, "R3 final drain", exp_q.size(), 0);

      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule